// File: doc/BRIEF.md
# Programmable Steerable Watchdog Timer

This block watches a processor for signs of life. Software programs a single 8-bit control register with a multiplier and a time unit. The timeout is the multiplier times the unit, counted in strobes of a slow base tick that arrives sixteen times a second. Any read or any write of that register counts as a kick and starts the period again. A multiplier of zero turns the watchdog off, and so does the power-on value of 00h.

A steering bit chooses what happens when the period runs out. With steering clear, the block sets a watchdog flag and holds an active-low interrupt until software reads the flag register or touches the watchdog register. The count then carries on from zero. With steering set, the block drives a fixed-length active-low reset pulse. When the pulse ends, the block clears its own register and asks the neighbouring logic to clear the frequency-test bit. While the watchdog is armed and steered to the interrupt, it also tells the frequency-test output to stay quiet.

Top module: `wdog_steer`

## Requirements
- R1: The register holds the steering bit in bit 7, the multiplier in bits 6..2 and the resolution code in bits 1..0. A write is stored at the clock edge where `wdr_wr` is high and appears on `wdr_rdata` from the next cycle.
- R2: Resolution code 00 selects 1 base tick, 01 selects 4, 10 selects 16 and 11 selects 64 (1/16 s, 1/4 s, 1 s, 4 s). The timeout is the multiplier times that many ticks. Expiry happens on the tick that completes the count, so 0Eh expires on the 48th tick after the last kick.
- R3: A cycle with `wdr_rd` or `wdr_wr` high resets the count to zero, and a tick that arrives in that same cycle is not counted.
- R4: With a multiplier of 0 the watchdog never expires, whatever the other bits hold.
- R5: With steering 0, expiry sets `wd_flag` and drives `irq_n` low from the next cycle. Both hold until a cycle with `flags_acc`, `wdr_rd` or `wdr_wr` high, and the count restarts from zero at once.
- R6: With steering 1, expiry drives `rst_out_n` low for PULSE_TICKS base ticks (default 2, which is 125 ms) and does not set `wd_flag`. The count is held at zero while the pulse lasts.
- R7: At the end of a reset pulse the register is cleared to 00h, and this takes priority over a write in the same cycle. `ft_clr` is high for exactly the one cycle in which `rst_out_n` returns high.
- R8: After reset the register reads 00h, `irq_n` and `rst_out_n` are high, and `wd_flag`, `ft_clr` and `ft_deny` are low.
- R9: `ft_deny` is high exactly when the multiplier is nonzero and the steering bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick | input | 1 | One-cycle strobe of the 16 Hz base tick |
| wdr_rd | input | 1 | Read access to the watchdog register this cycle |
| wdr_wr | input | 1 | Write access to the watchdog register this cycle |
| wdr_wdata | input | 8 | Write data for the watchdog register |
| flags_acc | input | 1 | Read or write access to the flag register this cycle |
| wdr_rdata | output | 8 | Current watchdog register contents |
| irq_n | output | 1 | Active-low interrupt request |
| rst_out_n | output | 1 | Active-low reset pulse |
| wd_flag | output | 1 | Watchdog flag |
| ft_clr | output | 1 | One-cycle request to clear the frequency-test bit |
| ft_deny | output | 1 | Suppress the frequency-test wave |

## Verification
The hardest cases to reach are the far ends of the period range. The longest unit takes 64 ticks per multiplier step, and the interrupt and reset outcomes must land on exactly the right tick. The bench therefore compresses the base tick to one strobe every four clocks, so that the 64-tick unit and a full reset pulse with its self-clear fit in a short run. A behavioural model follows every cycle. Kicks are placed just short of the timeout to show that the count really restarts and that a kick arriving on a tick wins.

// File: rtl/wdog_steer_pkg.sv
// Package: shared widths and the decoded view of the watchdog register.
// Assumes an 8-bit register made of one steering bit, the multiplier and the
// resolution code; each resolution step multiplies the unit by 2**RES_STEP.
package wdog_steer_pkg;
    localparam int MULT_W   = 5;
    localparam int RES_W    = 2;
    localparam int RES_STEP = 2;
    localparam int REG_W    = 1 + MULT_W + RES_W;
    localparam int CNT_W    = MULT_W + RES_STEP * ((1 << RES_W) - 1);

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } wd_cfg_t;
endpackage

// File: rtl/wdog_cfg_reg.sv
// Holds the watchdog register. Assumes one access per cycle at most.
// A clear request from the pulse logic takes priority over a write.
module wdog_cfg_reg
    import wdog_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr_req,
    output wd_cfg_t          cfg
);
    // Register storage with synchronous reset to the disabled value.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg <= '0;
        else if (clr_req) cfg <= '0;
        else if (wr)      cfg <= wd_cfg_t'(wdata);
    end
endmodule

// File: rtl/wdog_period_ctr.sv
// Counts base ticks up to multiplier * unit and strobes expire on the tick
// that completes the period. Assumes restart, hold and the disabled state all
// keep the count at zero, and that restart masks a tick in the same cycle.
module wdog_period_ctr
    import wdog_steer_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  wd_cfg_t cfg,
    input  logic    tick,
    input  logic    restart,
    input  logic    hold,
    output logic    expire
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             armed;

    // Period in ticks: the multiplier shifted by the resolution step.
    always_comb limit = CNT_W'(cfg.mult) << (RES_STEP * cfg.res);

    assign armed  = (cfg.mult != '0);
    assign expire = armed && !hold && !restart && tick
                    && (cnt_q == limit - CNT_W'(1));

    // Tick counter: cleared on kick, when disabled, during a pulse or at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || !armed || hold || expire)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + CNT_W'(1);
    end
endmodule

// File: rtl/wdog_expiry_ctrl.sv
// Turns an expiry into either a latched flag or a timed reset pulse,
// depending on the steering bit. Assumes expire never fires while a pulse is
// active. The flag is set on expiry with steering 0, and setting wins over
// clearing in the same cycle.
module wdog_expiry_ctrl #(
    parameter int PULSE_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic expire,
    input  logic steer,
    input  logic flag_clr,
    output logic flag_q,
    output logic pulse_q,
    output logic pulse_end
);
    localparam int PCNT_W = $clog2(PULSE_TICKS + 1);

    logic [PCNT_W-1:0] pcnt_q;

    assign pulse_end = pulse_q && tick && (pcnt_q == PCNT_W'(PULSE_TICKS - 1));

    // Watchdog flag for the interrupt steering.
    always_ff @(posedge clk) begin
        if (!rst_n)                flag_q <= 1'b0;
        else if (expire && !steer) flag_q <= 1'b1;
        else if (flag_clr)         flag_q <= 1'b0;
    end

    // Reset pulse timer, measured in base ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (expire && steer) begin
            pulse_q <= 1'b1;
            pcnt_q  <= '0;
        end else if (pulse_end) begin
            pulse_q <= 1'b0;
            pcnt_q  <= '0;
        end else if (pulse_q && tick) begin
            pcnt_q  <= pcnt_q + PCNT_W'(1);
        end
    end
endmodule

// File: rtl/wdog_steer.sv
// Top of the steerable watchdog. It joins the register, the period counter
// and the expiry control, and it drives the frequency-test clear and deny
// outputs. Assumes the bus raises at most one of wdr_rd and wdr_wr per cycle
// and that tick is a single-cycle strobe.
module wdog_steer
    import wdog_steer_pkg::*;
#(
    parameter int PULSE_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wdr_rd,
    input  logic             wdr_wr,
    input  logic [REG_W-1:0] wdr_wdata,
    input  logic             flags_acc,
    output logic [REG_W-1:0] wdr_rdata,
    output logic             irq_n,
    output logic             rst_out_n,
    output logic             wd_flag,
    output logic             ft_clr,
    output logic             ft_deny
);
    wd_cfg_t cfg;
    logic    kick, expire, flag_q, pulse_q, pulse_end, ft_clr_q;

    assign kick = wdr_rd || wdr_wr;

    wdog_cfg_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr(wdr_wr), .wdata(wdr_wdata),
        .clr_req(pulse_end), .cfg(cfg)
    );

    wdog_period_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .tick(tick),
        .restart(kick), .hold(pulse_q), .expire(expire)
    );

    wdog_expiry_ctrl #(.PULSE_TICKS(PULSE_TICKS)) u_exp (
        .clk(clk), .rst_n(rst_n), .tick(tick), .expire(expire),
        .steer(cfg.steer), .flag_clr(kick || flags_acc),
        .flag_q(flag_q), .pulse_q(pulse_q), .pulse_end(pulse_end)
    );

    // One-cycle frequency-test clear, aligned with the register self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) ft_clr_q <= 1'b0;
        else        ft_clr_q <= pulse_end;
    end

    assign wdr_rdata = REG_W'(cfg);
    assign irq_n     = !flag_q;
    assign rst_out_n = !pulse_q;
    assign wd_flag   = flag_q;
    assign ft_clr    = ft_clr_q;
    assign ft_deny   = (cfg.mult != '0) && !cfg.steer;
endmodule

// File: rtl/wdog_steer_chk.sv
// Checker for the steerable watchdog, bound to every instance of the top.
module wdog_steer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wdr_rd,
    input logic       wdr_wr,
    input logic [7:0] wdr_rdata,
    input logic       wd_flag,
    input logic       rst_out_n,
    input logic       ft_clr,
    input logic       ft_deny
);
    AST_KICK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wdr_rd || wdr_wr) |=> !wd_flag); // R5
    AST_KICK_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wdr_rd || wdr_wr) |=> !$fell(rst_out_n)); // R3
    AST_OFF_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wdr_rdata[6:2] == 5'd0) |=> !$rose(wd_flag)); // R4
    AST_OFF_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wdr_rdata[6:2] == 5'd0) |=> !$fell(rst_out_n)); // R4
    AST_FTCLR_REG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ft_clr |-> (wdr_rdata == 8'h00)); // R7
    AST_FTCLR_AT_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
        ft_clr |-> $rose(rst_out_n)); // R7
    AST_DENY_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        ft_deny |-> (wdr_rdata[6:2] != 5'd0)); // R9
endmodule

bind wdog_steer wdog_steer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wdr_rd(wdr_rd), .wdr_wr(wdr_wr),
    .wdr_rdata(wdr_rdata), .wd_flag(wd_flag), .rst_out_n(rst_out_n),
    .ft_clr(ft_clr), .ft_deny(ft_deny)
);

// File: tb/wdog_steer_bench.sv
module wdog_steer_bench;
    localparam int PULSE = 2;
    localparam int TPER  = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wdr_rd = 1'b0, wdr_wr = 1'b0, flags_acc = 1'b0;
    logic [7:0] wdr_wdata = 8'h00;
    logic [7:0] wdr_rdata;
    logic       irq_n, rst_out_n, wd_flag, ft_clr, ft_deny;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    wdog_steer #(.PULSE_TICKS(PULSE)) u_wdog_steer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wdr_rd(wdr_rd),
        .wdr_wr(wdr_wr), .wdr_wdata(wdr_wdata), .flags_acc(flags_acc),
        .wdr_rdata(wdr_rdata), .irq_n(irq_n), .rst_out_n(rst_out_n),
        .wd_flag(wd_flag), .ft_clr(ft_clr), .ft_deny(ft_deny)
    );

    // Base tick strobe: one cycle in every TPER.
    int tdiv = 0;
    always @(negedge clk) begin
        tdiv = (tdiv + 1) % TPER;
        tick <= (tdiv == 0);
    end

    // Behavioural reference model.
    logic [7:0] m_reg = 8'h00;
    int  m_cnt = 0, m_pcnt = 0;
    bit  m_wf = 0, m_pact = 0, m_ftc = 0;

    function automatic int unit_ticks(input int code);
        case (code)
            0: return 1;
            1: return 4;
            2: return 16;
            default: return 64;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reg = 8'h00; m_cnt = 0; m_pcnt = 0; m_wf = 0; m_pact = 0; m_ftc = 0;
        end else begin
            bit acc, fire, stop_p;
            int mult, tmo;
            acc    = wdr_rd || wdr_wr;
            mult   = int'(m_reg[6:2]);
            tmo    = mult * unit_ticks(int'(m_reg[1:0]));
            fire   = 0;
            stop_p = 0;
            if (m_pact) begin
                if (tick) begin
                    if (m_pcnt + 1 == PULSE) stop_p = 1;
                    else m_pcnt = m_pcnt + 1;
                end
                m_cnt = 0;
            end else if (acc || mult == 0) begin
                m_cnt = 0;
            end else if (tick) begin
                if (m_cnt + 1 == tmo) begin fire = 1; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end
            if (fire && !m_reg[7]) m_wf = 1;
            else if (acc || flags_acc) m_wf = 0;
            if (fire && m_reg[7]) begin m_pact = 1; m_pcnt = 0; end
            if (stop_p) begin m_pact = 0; m_pcnt = 0; end
            m_ftc = stop_p;
            if (stop_p) m_reg = 8'h00;
            else if (wdr_wr) m_reg = wdr_wdata;
        end
    end

    task automatic cmp1(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp1("R1 rdata",     int'(wdr_rdata), int'(m_reg));
            cmp1("R5 irq_n",     int'(irq_n),     int'(!m_wf));
            cmp1("R5 wd_flag",   int'(wd_flag),   int'(m_wf));
            cmp1("R6 rst_out_n", int'(rst_out_n), int'(!m_pact));
            cmp1("R7 ft_clr",    int'(ft_clr),    int'(m_ftc));
            cmp1("R9 ft_deny",   int'(ft_deny),
                 int'((m_reg[6:2] != 0) && !m_reg[7]));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] v);
        @(negedge clk); wdr_wr = 1'b1; wdr_wdata = v;
        @(negedge clk); wdr_wr = 1'b0;
    endtask

    task automatic rd_reg();
        @(negedge clk); wdr_rd = 1'b1;
        @(negedge clk); wdr_rd = 1'b0;
    endtask

    task automatic flag_touch();
        @(negedge clk); flags_acc = 1'b1;
        @(negedge clk); flags_acc = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        cmp1(tag, act, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int low;
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        // R8 reset state
        chk("R8 rdata", int'(wdr_rdata), 0);
        chk("R8 irq_n", int'(irq_n), 1);
        chk("R8 rst_out_n", int'(rst_out_n), 1);
        chk("R8 ft_deny", int'(ft_deny), 0);

        // R1/R2: 0Eh = 3 x 16 ticks, interrupt steering
        wr_reg(8'h0E);
        chk("R1 readback", int'(wdr_rdata), 8'h0E);
        chk("R9 deny armed", int'(ft_deny), 1);
        cyc(44 * TPER);
        chk("R2 before 48 ticks", int'(irq_n), 1);
        cyc(8 * TPER);
        chk("R2 after 48 ticks", int'(irq_n), 0);
        chk("R5 flag set", int'(wd_flag), 1);
        flag_touch();
        chk("R5 flag cleared by flags access", int'(wd_flag), 0);

        // R3: kick with reads every 40 ticks, never expires
        rd_reg();
        for (int k = 0; k < 4; k++) begin
            cyc(40 * TPER);
            rd_reg();
        end
        chk("R3 kicks prevent expiry", int'(irq_n), 1);
        cyc(52 * TPER);
        chk("R5 expiry after last kick", int'(wd_flag), 1);
        rd_reg();
        chk("R5 flag cleared by register read", int'(wd_flag), 0);

        // R2 shortest unit: 04h = 1 tick
        wr_reg(8'h04);
        flag_touch();
        cyc(3 * TPER);
        chk("R2 one-tick period", int'(wd_flag), 1);

        // R2 longest unit: 07h = 64 ticks
        wr_reg(8'h07);
        cyc(60 * TPER);
        chk("R2 64-tick not yet", int'(wd_flag), 0);
        cyc(8 * TPER);
        chk("R2 64-tick expired", int'(wd_flag), 1);

        // R4: multiplier 0 with other bits set stays quiet
        wr_reg(8'h83);
        chk("R9 deny off when disabled", int'(ft_deny), 0);
        flag_touch();
        cyc(300 * TPER);
        chk("R4 disabled no flag", int'(wd_flag), 0);
        chk("R4 disabled no pulse", int'(rst_out_n), 1);

        // R6/R7: 85h = steer, 1 x 4 ticks
        wr_reg(8'h85);
        chk("R9 deny off when steered", int'(ft_deny), 0);
        for (int w = 0; w < 40 && rst_out_n; w++) cyc(1);
        chk("R6 pulse started", int'(rst_out_n), 0);
        chk("R6 no flag in reset mode", int'(wd_flag), 0);
        low = 0;
        while (!rst_out_n && low < 100) begin
            low++;
            cyc(1);
        end
        chk("R6 pulse width in cycles", low, PULSE * TPER);
        chk("R7 ft_clr at pulse end", int'(ft_clr), 1);
        chk("R7 register self-cleared", int'(wdr_rdata), 0);
        cyc(1);
        chk("R7 ft_clr one cycle", int'(ft_clr), 0);

        cyc(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule